// File: doc/BRIEF.md
# Pulsed-Strobe Parallel Port Transmitter

This block moves words from an on-chip valid/ready stream onto a parallel printer-style port. Each accepted word is registered onto the data pins. After a programmable setup delay, the block drives a single active-low strobe pulse of programmable width. It then keeps the data still for a programmable hold delay and waits for the receiver's acknowledge pulse before it takes the next word. The port runs either 8 bits wide or the full data width. In the narrow setting, the upper data pins are driven low.

The receiver's busy and acknowledge lines pass through a synchronizer before any decision uses them. Busy flow control is optional. When enabled, the strobe is held off for as long as the receiver reports busy. It is honoured only in the narrow setting, because in the wide setting the busy line is a data pin. The block does not rely on any fixed ordering between the end of busy and the acknowledge pulse. If no acknowledge arrives within a programmable limit, a one-cycle error pulse is raised and the block returns to idle.

All timing fields are 8-bit values N that give N+1 clocks, so each interval covers 1 to 256 clocks. The configuration inputs must be held steady while a word is in flight.

Top module: `par_pulse_tx`

## Requirements
- R1: During and directly after reset, pStrobeN is 1, sReady is 1, errTimeout is 0 and pData is 0.
- R2: sReady is 1 only while the block is idle. A word is captured on the clock edge where sValid and sReady are both 1, and pData stays unchanged until the next capture. With cfgWide=0, bits DATA_W-1..8 of the captured word are driven 0. With cfgWide=1, all bits are driven as given.
- R3: With busy gating inactive, pStrobeN falls on the (cfgSetup+1)-th clock edge after the capture edge.
- R4: pStrobeN stays low for exactly cfgWidth+1 clocks.
- R5: After pStrobeN rises, sReady stays 0 for at least cfgHold+2 clocks: cfgHold+1 clocks of hold, then at least one clock of waiting for the acknowledge.
- R6: With cfgBusyGate=1 and cfgWide=0, a synchronized busyIn of 1 keeps pStrobeN high once setup has elapsed. pStrobeN falls on the third clock edge after busyIn drops (two synchronizer stages, then the decision edge).
- R7: With cfgBusyGate=0, or with cfgWide=1, busyIn has no effect and the setup timing of R3 holds with busyIn=1.
- R8: After the strobe, a new word is accepted only once a rising edge of ackIn has been seen. Once hold has elapsed, sReady rises on the fourth clock edge after ackIn rises. Transfers complete with busyIn falling before, together with, or after the acknowledge pulse.
- R9: If no ackIn rising edge is seen, errTimeout pulses high for exactly one clock, cfgHold+cfgTimeout+2 clocks after pStrobeN rises, and sReady returns to 1 in the same cycle.
- R10: An ackIn rising edge that arrives while the strobe is low or during hold is remembered. sReady then rises exactly cfgHold+2 clocks after pStrobeN rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWide | input | 1 | 1 selects full-width data, 0 selects 8-bit data |
| cfgBusyGate | input | 1 | 1 lets busy hold off the strobe (narrow mode only) |
| cfgSetup | input | TPAR_W | Setup interval, value N gives N+1 clocks |
| cfgWidth | input | TPAR_W | Strobe width, value N gives N+1 clocks |
| cfgHold | input | TPAR_W | Hold interval, value N gives N+1 clocks |
| cfgTimeout | input | TMO_W | Acknowledge wait limit, value N gives N+1 clocks |
| sValid | input | 1 | Upstream word valid |
| sReady | output | 1 | Block idle and able to take a word |
| sData | input | DATA_W | Upstream word |
| busyIn | input | 1 | Receiver busy, asynchronous |
| ackIn | input | 1 | Receiver acknowledge pulse, asynchronous, active high |
| pData | output | DATA_W | Registered port data |
| pStrobeN | output | 1 | Registered active-low strobe |
| errTimeout | output | 1 | One-clock pulse on acknowledge timeout |

## Verification
The bench builds the block with DATA_W=16, TPAR_W=8, TMO_W=10 and SYNC_STAGES=2. The 16-bit width puts both the narrow masking and the wide pass-through within reach. The 8-bit timing fields allow the full 256-clock setup, width and hold to be run end to end in under a thousand cycles. The 10-bit timeout field keeps timeout runs short. Two synchronizer stages fix the latencies from busy and acknowledge to the ports, so the bench can check those latencies exactly, including the remembered-early acknowledge and every ordering of busy release against acknowledge.

// File: rtl/pstx_pkg.sv
package pstx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_ACKWAIT
  } txState_t;

  typedef enum logic [1:0] {
    LD_SETUP,
    LD_WIDTH,
    LD_HOLD,
    LD_TMO
  } cntSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    strbOn;
    logic    strbOff;
    logic    cntLoad;
    cntSel_t cntSel;
    logic    cntDec;
    logic    errSet;
  } txCtl_t;

endpackage

// File: rtl/pstx_sync.sv
module pstx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pstx_ctrl.sv
module pstx_ctrl
  import pstx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sValid,
  input  logic   cfgWide,
  input  logic   cfgBusyGate,
  input  logic   busySync,
  input  logic   ackSync,
  input  logic   cntZero,
  output logic   sReady,
  output txCtl_t ctl
);

  txState_t state, stateNext;
  logic     ackPrev;
  logic     ackSeen;
  logic     ackRise;
  logic     gateOn;
  logic     afterStrobe;

  assign gateOn      = cfgBusyGate & ~cfgWide;
  assign ackRise     = ackSync & ~ackPrev;
  assign afterStrobe = (state == ST_STROBE) || (state == ST_HOLD) ||
                       (state == ST_ACKWAIT);
  assign sReady      = (state == ST_IDLE);

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (sValid) begin
          ctl.capture = 1'b1;
          ctl.cntLoad = 1'b1;
          ctl.cntSel  = LD_SETUP;
          stateNext   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (!cntZero) begin
          ctl.cntDec = 1'b1;
        end else if (!(gateOn && busySync)) begin
          ctl.strbOn  = 1'b1;
          ctl.cntLoad = 1'b1;
          ctl.cntSel  = LD_WIDTH;
          stateNext   = ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (!cntZero) begin
          ctl.cntDec = 1'b1;
        end else begin
          ctl.strbOff = 1'b1;
          ctl.cntLoad = 1'b1;
          ctl.cntSel  = LD_HOLD;
          stateNext   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!cntZero) begin
          ctl.cntDec = 1'b1;
        end else begin
          ctl.cntLoad = 1'b1;
          ctl.cntSel  = LD_TMO;
          stateNext   = ST_ACKWAIT;
        end
      end
      ST_ACKWAIT: begin
        if (ackSeen) begin
          stateNext = ST_IDLE;
        end else if (cntZero) begin
          ctl.errSet = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          ctl.cntDec = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ackPrev <= 1'b0;
      ackSeen <= 1'b0;
    end else begin
      state   <= stateNext;
      ackPrev <= ackSync;
      if (ctl.capture)
        ackSeen <= 1'b0;
      else if (ackRise && afterStrobe)
        ackSeen <= 1'b1;
    end
  end

endmodule

// File: rtl/pstx_dp.sv
module pstx_dp
  import pstx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TPAR_W = 8,
  parameter int TMO_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtl_t            ctl,
  input  logic              cfgWide,
  input  logic [TPAR_W-1:0] cfgSetup,
  input  logic [TPAR_W-1:0] cfgWidth,
  input  logic [TPAR_W-1:0] cfgHold,
  input  logic [TMO_W-1:0]  cfgTimeout,
  input  logic [DATA_W-1:0] sData,
  output logic [DATA_W-1:0] pData,
  output logic              pStrobeN,
  output logic              errTimeout,
  output logic              cntZero
);

  localparam int NARROW_W = 8;
  localparam int CNT_W    = (TMO_W > TPAR_W) ? TMO_W : TPAR_W;
  localparam logic [DATA_W-1:0] LOW_MASK =
    DATA_W'((64'd1 << NARROW_W) - 64'd1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (ctl.cntSel)
      LD_SETUP: loadVal = CNT_W'(cfgSetup);
      LD_WIDTH: loadVal = CNT_W'(cfgWidth);
      LD_HOLD:  loadVal = CNT_W'(cfgHold);
      default:  loadVal = CNT_W'(cfgTimeout);
    endcase
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      pData      <= '0;
      pStrobeN   <= 1'b1;
      errTimeout <= 1'b0;
    end else begin
      if (ctl.cntLoad)     cnt <= loadVal;
      else if (ctl.cntDec) cnt <= cnt - 1'b1;

      if (ctl.capture)
        pData <= cfgWide ? sData : (sData & LOW_MASK);

      if (ctl.strbOn)       pStrobeN <= 1'b0;
      else if (ctl.strbOff) pStrobeN <= 1'b1;

      errTimeout <= ctl.errSet;
    end
  end

endmodule

// File: rtl/par_pulse_tx.sv
module par_pulse_tx
  import pstx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int TPAR_W      = 8,
  parameter int TMO_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWide,
  input  logic              cfgBusyGate,
  input  logic [TPAR_W-1:0] cfgSetup,
  input  logic [TPAR_W-1:0] cfgWidth,
  input  logic [TPAR_W-1:0] cfgHold,
  input  logic [TMO_W-1:0]  cfgTimeout,
  input  logic              sValid,
  output logic              sReady,
  input  logic [DATA_W-1:0] sData,
  input  logic              busyIn,
  input  logic              ackIn,
  output logic [DATA_W-1:0] pData,
  output logic              pStrobeN,
  output logic              errTimeout
);

  txCtl_t     ctl;
  logic       cntZero;
  logic       busySync;
  logic       ackSync;
  logic [1:0] syncOut;

  pstx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({busyIn, ackIn}),
    .dout (syncOut)
  );

  assign busySync = syncOut[1];
  assign ackSync  = syncOut[0];

  pstx_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sValid      (sValid),
    .cfgWide     (cfgWide),
    .cfgBusyGate (cfgBusyGate),
    .busySync    (busySync),
    .ackSync     (ackSync),
    .cntZero     (cntZero),
    .sReady      (sReady),
    .ctl         (ctl)
  );

  pstx_dp #(.DATA_W(DATA_W), .TPAR_W(TPAR_W), .TMO_W(TMO_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cfgWide    (cfgWide),
    .cfgSetup   (cfgSetup),
    .cfgWidth   (cfgWidth),
    .cfgHold    (cfgHold),
    .cfgTimeout (cfgTimeout),
    .sData      (sData),
    .pData      (pData),
    .pStrobeN   (pStrobeN),
    .errTimeout (errTimeout),
    .cntZero    (cntZero)
  );

endmodule

// File: rtl/par_pulse_tx_chk.sv
module par_pulse_tx_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWide,
  input logic              cfgBusyGate,
  input logic              sValid,
  input logic              sReady,
  input logic [DATA_W-1:0] pData,
  input logic              pStrobeN,
  input logic              errTimeout,
  input logic              busySync
);

  // R1: idle outputs while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_idle_r1: assert (pStrobeN && sReady && !errTimeout);
    end
  end

  // R2: never ready while the strobe is active
  p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    !pStrobeN |-> !sReady);

  // R2: port data frozen between captures
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!sReady && $past(!sReady)) |-> $stable(pData));

  // R2: narrow capture clears the upper pins
  p_narrow_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sReady && !cfgWide) |=> ((pData >> 8) == '0));

  // R5: strobe release enters hold, not idle
  p_hold_after_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pStrobeN) |-> !sReady);

  // R6: synchronized busy keeps the strobe off in gated narrow mode
  p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBusyGate && !cfgWide && busySync && pStrobeN) |=> pStrobeN);

  // R9: timeout flag is a single-cycle pulse
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |=> !errTimeout);

  // R9: timeout returns the block to idle
  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |-> sReady);

endmodule

bind par_pulse_tx par_pulse_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWide     (cfgWide),
  .cfgBusyGate (cfgBusyGate),
  .sValid      (sValid),
  .sReady      (sReady),
  .pData       (pData),
  .pStrobeN    (pStrobeN),
  .errTimeout  (errTimeout),
  .busySync    (busySync)
);

// File: tb/par_pulse_tx_test.sv
module par_pulse_tx_test;

  localparam int DATA_W      = 16;
  localparam int TPAR_W      = 8;
  localparam int TMO_W       = 10;
  localparam int SYNC_STAGES = 2;

  logic              clk;
  logic              rstN;
  logic              cfgWide;
  logic              cfgBusyGate;
  logic [TPAR_W-1:0] cfgSetup;
  logic [TPAR_W-1:0] cfgWidth;
  logic [TPAR_W-1:0] cfgHold;
  logic [TMO_W-1:0]  cfgTimeout;
  logic              sValid;
  logic              sReady;
  logic [DATA_W-1:0] sData;
  logic              busyIn;
  logic              ackIn;
  logic [DATA_W-1:0] pData;
  logic              pStrobeN;
  logic              errTimeout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // responder controls
  bit  respEn    = 0;
  bit  earlyAck  = 0;
  bit  gateCheck = 0;
  int  busyMode  = 0;
  int  ackDelay  = 2;
  int  rxCount   = 0;
  logic [DATA_W-1:0] rxLog [64];
  logic lastBusy;

  par_pulse_tx #(
    .DATA_W(DATA_W), .TPAR_W(TPAR_W), .TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .cfgBusyGate(cfgBusyGate),
    .cfgSetup(cfgSetup), .cfgWidth(cfgWidth), .cfgHold(cfgHold),
    .cfgTimeout(cfgTimeout), .sValid(sValid), .sReady(sReady), .sData(sData),
    .busyIn(busyIn), .ackIn(ackIn), .pData(pData), .pStrobeN(pStrobeN),
    .errTimeout(errTimeout)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Receiver model: logs data at each strobe, drives busy and ack
  initial begin
    busyIn = 1'b0;
    ackIn  = 1'b0;
    lastBusy = 1'b0;
    forever begin
      do begin
        lastBusy = busyIn;
        @(negedge clk);
      end while (!(respEn && !pStrobeN));
      if (gateCheck)
        check(lastBusy == 1'b0, "R6", "busy low before strobe", lastBusy, 0);
      if (rxCount < 64) rxLog[rxCount] = pData;
      rxCount++;
      if (earlyAck) begin
        ackIn = 1'b1;
        repeat (2) @(negedge clk);
        ackIn = 1'b0;
      end
      if (busyMode != 0) busyIn = 1'b1;
      while (!pStrobeN) @(negedge clk);
      if (!earlyAck) begin
        repeat (ackDelay) @(negedge clk);
        if (busyMode == 1) begin
          busyIn = 1'b0;
          @(negedge clk);
        end
        if (busyMode == 2) busyIn = 1'b0;
        ackIn = 1'b1;
        repeat (2) @(negedge clk);
        ackIn = 1'b0;
        if (busyMode == 3) begin
          repeat (3) @(negedge clk);
          busyIn = 1'b0;
        end
      end
    end
  end

  // One word through the port; measures setup, width and hold phases
  task automatic xfer(input logic [DATA_W-1:0] word, input bit chkSetup,
                      input int holdExact);
    logic [DATA_W-1:0] expData;
    int n;
    int w;
    int h;
    bit stable;
    int guard;
    expData = cfgWide ? word : (word & 16'h00FF);
    guard = 0;
    while (!sReady && guard < 2000) begin
      guard++;
      @(negedge clk);
    end
    sValid = 1'b1;
    sData  = word;
    @(negedge clk);
    sValid = 1'b0;
    sData  = ~word;
    check(sReady == 1'b0, "R2", "ready low after accept", sReady, 0);
    check(pData == expData, "R2", "captured port data", pData, expData);
    n = 0;
    while (pStrobeN && n < 2000) begin
      n++;
      @(negedge clk);
    end
    if (chkSetup)
      check(n == int'(cfgSetup) + 1, "R3", "setup clocks", n, int'(cfgSetup) + 1);
    w = 0;
    stable = 1;
    while (!pStrobeN && w < 2000) begin
      w++;
      if (pData != expData) stable = 0;
      @(negedge clk);
    end
    check(w == int'(cfgWidth) + 1, "R4", "strobe width", w, int'(cfgWidth) + 1);
    check(stable, "R2", "data stable during strobe", stable, 1);
    if (respEn) begin
      h = 0;
      stable = 1;
      while (!sReady && h < 2000) begin
        h++;
        if (pData != expData || errTimeout) stable = 0;
        @(negedge clk);
      end
      check(h >= int'(cfgHold) + 2, "R5", "ready low after strobe", h,
            int'(cfgHold) + 2);
      check(stable, "R8", "data held and no timeout with ack", stable, 1);
      if (holdExact > 0)
        check(h == holdExact, "R8", "ready latency after strobe", h, holdExact);
    end
  endtask

  task automatic setTiming(input int s, input int wd, input int hd, input int t);
    cfgSetup   = TPAR_W'(s);
    cfgWidth   = TPAR_W'(wd);
    cfgHold    = TPAR_W'(hd);
    cfgTimeout = TMO_W'(t);
  endtask

  task automatic t_reset();
    check(pStrobeN == 1'b1, "R1", "strobe idle high", pStrobeN, 1);
    check(sReady == 1'b1, "R1", "ready after reset", sReady, 1);
    check(errTimeout == 1'b0, "R1", "no error after reset", errTimeout, 0);
    check(pData == '0, "R1", "data zero after reset", pData, 0);
  endtask

  task automatic t_narrow();
    cfgWide = 0; cfgBusyGate = 0; busyMode = 0; ackDelay = 2; respEn = 1;
    setTiming(2, 1, 1, 40);
    rxCount = 0;
    xfer(16'hA5C3, 1, 0);
    xfer(16'h1234, 1, 0);
    xfer(16'hFF00, 1, 0);
    check(rxCount == 3, "R2", "narrow words strobed", rxCount, 3);
    check(rxLog[0] == 16'h00C3, "R2", "narrow word 0", rxLog[0], 16'h00C3);
    check(rxLog[2] == 16'h0000, "R2", "narrow word 2", rxLog[2], 0);
  endtask

  task automatic t_wide();
    cfgWide = 1; cfgBusyGate = 0; busyMode = 0; ackDelay = 2; respEn = 1;
    setTiming(0, 0, 0, 40);
    rxCount = 0;
    xfer(16'hA5C3, 1, 0);
    setTiming(5, 3, 2, 40);
    xfer(16'h8001, 1, 0);
    check(rxLog[0] == 16'hA5C3, "R2", "wide word 0", rxLog[0], 16'hA5C3);
    check(rxLog[1] == 16'h8001, "R2", "wide word 1", rxLog[1], 16'h8001);
  endtask

  task automatic t_max_timing();
    cfgWide = 1; cfgBusyGate = 0; busyMode = 0; ackDelay = 2; respEn = 1;
    setTiming(255, 255, 255, 40);
    xfer(16'h5A5A, 1, 0);
  endtask

  task automatic t_ack_wait();
    cfgWide = 0; cfgBusyGate = 0; busyMode = 0; ackDelay = 12; respEn = 1;
    setTiming(1, 1, 1, 60);
    // R8: ready follows ack rise by sync stages plus edge detect plus exit
    xfer(16'h0077, 1, 12 + SYNC_STAGES + 2);
    ackDelay = 2;
  endtask

  task automatic t_ack_early();
    cfgWide = 0; cfgBusyGate = 0; busyMode = 0; respEn = 1; earlyAck = 1;
    setTiming(1, 4, 3, 40);
    // R10: early ack remembered, ready right after hold plus one wait cycle
    xfer(16'h0042, 1, 3 + 2);
    earlyAck = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    respEn = 1; busyMode = 0; ackDelay = 2;
    setTiming(3, 1, 1, 40);
    busyIn = 1'b1;
    cfgWide = 1; cfgBusyGate = 1;
    xfer(16'hBEEF, 1, 0);   // R7 wide mode ignores busy
    cfgWide = 0; cfgBusyGate = 0;
    xfer(16'h00EF, 1, 0);   // R7 gate off ignores busy
    busyIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_busy_gate();
    int c;
    int guard;
    respEn = 1; busyMode = 0; ackDelay = 2;
    cfgWide = 0; cfgBusyGate = 1;
    setTiming(0, 1, 1, 40);
    busyIn = 1'b1;
    repeat (4) @(negedge clk);
    guard = 0;
    while (!sReady && guard < 100) begin
      guard++;
      @(negedge clk);
    end
    sValid = 1'b1;
    sData  = 16'h0033;
    @(negedge clk);
    sValid = 1'b0;
    c = 0;
    repeat (30) begin
      if (pStrobeN) c++;
      @(negedge clk);
    end
    check(c == 30, "R6", "strobe held off while busy", c, 30);
    busyIn = 1'b0;
    @(negedge clk);
    c = 0;
    while (pStrobeN && c < 20) begin
      c++;
      @(negedge clk);
    end
    check(c == SYNC_STAGES, "R6", "strobe after busy release", c, SYNC_STAGES);
    guard = 0;
    while (!sReady && guard < 200) begin
      guard++;
      @(negedge clk);
    end
    check(sReady == 1'b1, "R6", "gated transfer completes", sReady, 1);
  endtask

  task automatic t_busy_orders();
    respEn = 1; ackDelay = 3; gateCheck = 1;
    cfgWide = 0; cfgBusyGate = 1;
    setTiming(1, 2, 1, 80);
    for (int m = 1; m <= 3; m++) begin
      busyMode = m;
      rxCount = 0;
      xfer(16'h0011 * m[15:0], 0, 0);
      xfer(16'h0022 * m[15:0], 0, 0);
      xfer(16'h0044 * m[15:0], 0, 0);
      check(rxCount == 3, "R8", "words with busy ordering", rxCount, 3);
      check(rxLog[2] == ((16'h0044 * m[15:0]) & 16'h00FF), "R8",
            "last word with busy ordering", rxLog[2],
            (16'h0044 * m[15:0]) & 16'h00FF);
      repeat (8) @(negedge clk);
    end
    busyMode = 0; gateCheck = 0; busyIn = 1'b0;
  endtask

  task automatic t_timeout();
    int e;
    respEn = 0;
    cfgWide = 0; cfgBusyGate = 0;
    setTiming(1, 1, 1, 20);
    xfer(16'h0099, 1, 0);
    e = 0;
    while (!errTimeout && e < 500) begin
      check(sReady == 1'b0, "R9", "not ready before timeout", sReady, 0);
      e++;
      @(negedge clk);
    end
    check(e == 1 + 20 + 2, "R9", "timeout delay", e, 23);
    check(sReady == 1'b1, "R9", "idle at timeout", sReady, 1);
    @(negedge clk);
    check(errTimeout == 1'b0, "R9", "error is one clock", errTimeout, 0);
    respEn = 1; ackDelay = 2;
    xfer(16'h0055, 1, 0);   // R9 recovers for next word
  endtask

  initial begin
    rstN = 1'b0;
    cfgWide = 0; cfgBusyGate = 0;
    cfgSetup = '0; cfgWidth = '0; cfgHold = '0; cfgTimeout = '0;
    sValid = 1'b0; sData = '0;
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_wide();
    t_max_timing();
    t_ack_wait();
    t_ack_early();
    t_busy_ignore();
    t_busy_gate();
    t_busy_orders();
    t_timeout();
    repeat (5) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule